// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block holds the coherence state of every line of a small private write-back cache and sits between the local processor and a shared snooping bus. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. A processor request carries a line index and a read/write flag. The controller answers it at once when the current state permits. Otherwise it raises a bus read or a bus read-for-ownership (RFO), waits for the grant, and collects one snoop response from every other agent before it commits the new state and reports completion.

Bus traffic raised by other agents arrives as snoops. For each snoop the controller reports, one cycle later, whether it held a copy and whether it must supply dirty data, and it lowers the line's state to match. The line index is taken to be already resolved: tag comparison, data storage, replacement, arbitration and the memory controller sit outside the block. When a snoop and a local request name the same line in the same cycle, the snoop is applied first. The local request waits one cycle and is then judged against the updated state.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: The reset state (`rst_n` low at a clock edge) leaves every line Invalid, so a snoop to any line then reports neither a copy nor dirty data.
- R2: A write to an Invalid line raises a bus request with `bus_req_rfo`=1 (1 means RFO, 0 means plain read) for that line; after it completes, the line is Modified and `cpu_done` reports `cpu_hit`=0.
- R3: A read to an Invalid line raises a bus request with `bus_req_rfo`=0. The request is held until `bus_grant`. The line then becomes Shared if any peer response carried `peer_resp_shared`=1, and Exclusive otherwise.
- R4: A read or write to a Modified line completes with `cpu_hit`=1 in the cycle after acceptance, without any bus request and without a state change.
- R5: A snoop read to a Modified line answers with shared=1 and supply=1 and leaves the line Shared.
- R6: A snoop RFO to a Modified line answers with shared=1 and supply=1 and leaves the line Invalid.
- R7: A read to a Shared line hits. A write to a Shared line raises an RFO and ends with the line Modified and `cpu_hit`=0.
- R8: A snoop read to a Shared line answers shared=1 and supply=0 and keeps it Shared. A snoop RFO to a Shared line answers supply=0 and leaves it Invalid.
- R9: A write to an Exclusive line completes as a hit with no bus request and leaves the line Modified. A read to an Exclusive line also hits.
- R10: A bus transaction does not complete, and `cpu_done` stays low, until every one of the `NUM_PEERS` peers has returned a response. A peer's response is a pulse on its bit of `peer_resp_valid`, one per peer, in any order.
- R11: A snoop read to an Exclusive line answers shared=1 and supply=0 and leaves it Shared. A snoop RFO to an Exclusive line leaves it Invalid.
- R12: A snoop to the line of a waiting local request in the same cycle takes effect first. The local request produces neither `cpu_done` nor a bus request in the following cycle, and it is then served according to the post-snoop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_line | input | IDX_W | Line index of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | With `cpu_done`: 1 if served without a bus transaction |
| bus_req_valid | output | 1 | Bus transaction requested, held until granted |
| bus_req_rfo | output | 1 | 1 = read-for-ownership, 0 = read |
| bus_req_line | output | IDX_W | Line index of the bus transaction |
| bus_grant | input | 1 | Arbiter grant pulse |
| peer_resp_valid | input | NUM_PEERS | Per-peer snoop response pulse |
| peer_resp_shared | input | NUM_PEERS | Per-peer "holds a copy" flag, qualified by valid |
| snoop_valid | input | 1 | Transaction from another agent observed |
| snoop_rfo | input | 1 | 1 = snooped RFO, 0 = snooped read |
| snoop_line | input | IDX_W | Line index of the snooped transaction |
| snoop_resp_valid | output | 1 | Snoop answer, one cycle after `snoop_valid` |
| snoop_resp_shared | output | 1 | This cache held a copy |
| snoop_resp_supply | output | 1 | This cache supplies dirty data |

## Verification
The assertions take the bus side to be well formed. Peer responses arrive only while a transaction of this controller awaits them, with at most one pulse per peer, and `bus_grant` arrives only while a request is raised. They also take snoops never to describe this controller's own transactions. The bench plays the arbiter and the peers. It grants only a visible request and then pulses each peer bit exactly once, with random gaps. Snoops are issued only between local requests, apart from the directed same-line collision, so all stimulus stays inside these assumptions.

// File: rtl/mesi_pkg.sv
// Shared types for the coherence controller: the per-line state encoding
// and the state a line takes after a snooped transaction.
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    // State after another agent's read (rfo=0) or read-for-ownership (rfo=1).
    function automatic line_st_t snoop_next(line_st_t cur, logic rfo);
        if (rfo)
            return ST_I;
        else if (cur == ST_I)
            return ST_I;
        else
            return ST_S;
    endfunction

endpackage

// File: rtl/mesi_line_array.sv
// Per-line coherence state storage with two write ports.
// Assumes the snoop port and the local port never write the same line in
// one cycle (the request FSM stalls on such a collision); the snoop port
// is given priority anyway.
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_t         snp_st,
    input  logic             loc_we,
    input  logic [IDX_W-1:0] loc_idx,
    input  line_st_t         loc_st,
    output line_st_t         st_q [NUM_LINES]
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Hold one line's state; a snoop update wins over a local one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[g] <= ST_I;
            else if (snp_we && (snp_idx == IDX_W'(g)))
                st_q[g] <= snp_st;
            else if (loc_we && (loc_idx == IDX_W'(g)))
                st_q[g] <= loc_st;
        end

        // R1: a reset cycle leaves the line Invalid.
        a_r1_reset_invalid: assert property (@(posedge clk)
            $past(!rst_n) |-> st_q[g] == ST_I);
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
// Snoop responder: turns an observed transaction of another agent into a
// state update for the addressed line and a registered answer one cycle
// later. Assumes snoops never describe this controller's own transactions.
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     snoop_valid,
    input  logic     snoop_rfo,
    input  line_st_t cur_st,
    output logic     upd_we,
    output line_st_t upd_st,
    output logic     resp_valid,
    output logic     resp_shared,
    output logic     resp_supply
);

    // Compute the state update applied in the snoop cycle.
    always_comb begin
        upd_we = snoop_valid;
        upd_st = snoop_next(cur_st, snoop_rfo);
    end

    // Register the answer: a copy was held, and it was dirty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_shared <= 1'b0;
            resp_supply <= 1'b0;
        end else begin
            resp_valid  <= snoop_valid;
            resp_shared <= snoop_valid && (cur_st != ST_I);
            resp_supply <= snoop_valid && (cur_st == ST_M);
        end
    end

    // R5/R6: dirty data is only ever supplied from a held copy.
    a_r5_supply_has_copy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_supply |-> resp_shared && resp_valid);

    // R8/R11: a clean line never supplies data.
    a_r8_clean_no_supply: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && (cur_st != ST_M) |=> !resp_supply);

endmodule

// File: rtl/mesi_req_fsm.sv
// Processor-side request sequencer. Decides hit or bus transaction from the
// line's current state, holds the bus request until granted, gathers one
// response from every peer and commits the final state.
// Assumes peers answer only while a transaction is collecting, once each,
// and that the grant only arrives while a request is raised.
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PEERS = 3,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int CNT_W = $clog2(NUM_PEERS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req_valid,
    input  logic                 cpu_req_write,
    input  logic [IDX_W-1:0]     cpu_req_line,
    input  line_st_t             cur_st,
    input  logic                 snoop_valid,
    input  logic [IDX_W-1:0]     snoop_line,
    input  logic                 bus_grant,
    input  logic [NUM_PEERS-1:0] peer_resp_valid,
    input  logic [NUM_PEERS-1:0] peer_resp_shared,
    output logic                 cpu_done,
    output logic                 cpu_hit,
    output logic                 bus_req_valid,
    output logic                 bus_req_rfo,
    output logic [IDX_W-1:0]     bus_req_line,
    output logic                 loc_we,
    output logic [IDX_W-1:0]     loc_idx,
    output line_st_t             loc_st
);

    typedef enum logic [1:0] {F_IDLE, F_BUSREQ, F_COLLECT, F_DONE} fsm_t;

    fsm_t                 state_q;
    logic [IDX_W-1:0]     pend_line_q;
    logic                 pend_rfo_q;
    logic [NUM_PEERS-1:0] got_q;
    logic                 shr_q;
    logic                 hit_q;

    logic                 accept;
    logic                 needs_bus;
    logic                 need_rfo;
    logic                 finish;
    logic [NUM_PEERS-1:0] got_nxt;
    logic                 shr_nxt;

    // Decide acceptance, bus need and completion for this cycle.
    always_comb begin
        accept    = (state_q == F_IDLE) && cpu_req_valid &&
                    !(snoop_valid && (snoop_line == cpu_req_line));
        need_rfo  = cpu_req_write && ((cur_st == ST_I) || (cur_st == ST_S));
        needs_bus = (cur_st == ST_I) || need_rfo;
        got_nxt   = got_q | peer_resp_valid;
        shr_nxt   = shr_q | (|(peer_resp_valid & peer_resp_shared));
        finish    = (state_q == F_COLLECT) && (&got_nxt) &&
                    !(snoop_valid && (snoop_line == pend_line_q));
    end

    // Drive the local state-write port: silent upgrade or transaction commit.
    always_comb begin
        loc_we  = 1'b0;
        loc_idx = cpu_req_line;
        loc_st  = ST_M;
        if (finish) begin
            loc_we  = 1'b1;
            loc_idx = pend_line_q;
            loc_st  = pend_rfo_q ? ST_M : (shr_nxt ? ST_S : ST_E);
        end else if (accept && cpu_req_write && (cur_st == ST_E)) begin
            loc_we  = 1'b1;
        end
    end

    // Sequence the request through bus request, collection and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= F_IDLE;
            pend_line_q <= '0;
            pend_rfo_q  <= 1'b0;
            got_q       <= '0;
            shr_q       <= 1'b0;
            hit_q       <= 1'b0;
        end else begin
            case (state_q)
                F_IDLE: begin
                    got_q <= '0;
                    shr_q <= 1'b0;
                    if (accept) begin
                        pend_line_q <= cpu_req_line;
                        pend_rfo_q  <= need_rfo;
                        hit_q       <= !needs_bus;
                        state_q     <= needs_bus ? F_BUSREQ : F_DONE;
                    end
                end
                F_BUSREQ: begin
                    if (bus_grant)
                        state_q <= F_COLLECT;
                end
                F_COLLECT: begin
                    got_q <= got_nxt;
                    shr_q <= shr_nxt;
                    if (finish)
                        state_q <= F_DONE;
                end
                default: state_q <= F_IDLE;
            endcase
        end
    end

    assign cpu_done      = (state_q == F_DONE);
    assign cpu_hit       = (state_q == F_DONE) && hit_q;
    assign bus_req_valid = (state_q == F_BUSREQ);
    assign bus_req_rfo   = pend_rfo_q;
    assign bus_req_line  = pend_line_q;

    // Count distinct peer answers for the completion check below.
    logic [CNT_W-1:0] resp_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || bus_req_valid)
            resp_cnt_q <= '0;
        else if (state_q == F_COLLECT)
            resp_cnt_q <= resp_cnt_q + CNT_W'($countones(peer_resp_valid & ~got_q));
    end

    // R10: a bus-served completion only after every peer answered.
    a_r10_all_peers: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && !cpu_hit |-> resp_cnt_q == CNT_W'(NUM_PEERS));

    // R3: a raised bus request holds steady until granted.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_grant |=>
            bus_req_valid && $stable(bus_req_line) && $stable(bus_req_rfo));

    // R4: a hit completes straight from idle with no bus request before it.
    a_r4_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_hit |-> !$past(bus_req_valid) && !bus_req_valid);

    // R12: a same-line snoop stalls an idle request for one cycle.
    a_r12_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_IDLE) && cpu_req_valid && snoop_valid &&
        (snoop_line == cpu_req_line) |=> !cpu_done && !bus_req_valid);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the four-state coherence controller for one private cache.
// Wires the line-state array to the snoop responder and the processor
// request sequencer. Line indices arrive already resolved by the cache.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PEERS = 3,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req_valid,
    input  logic                 cpu_req_write,
    input  logic [IDX_W-1:0]     cpu_req_line,
    output logic                 cpu_done,
    output logic                 cpu_hit,
    output logic                 bus_req_valid,
    output logic                 bus_req_rfo,
    output logic [IDX_W-1:0]     bus_req_line,
    input  logic                 bus_grant,
    input  logic [NUM_PEERS-1:0] peer_resp_valid,
    input  logic [NUM_PEERS-1:0] peer_resp_shared,
    input  logic                 snoop_valid,
    input  logic                 snoop_rfo,
    input  logic [IDX_W-1:0]     snoop_line,
    output logic                 snoop_resp_valid,
    output logic                 snoop_resp_shared,
    output logic                 snoop_resp_supply
);

    line_st_t         st_vec [NUM_LINES];
    logic             snp_we;
    line_st_t         snp_st;
    logic             loc_we;
    logic [IDX_W-1:0] loc_idx;
    line_st_t         loc_st;

    mesi_line_array #(.NUM_LINES(NUM_LINES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .snp_we  (snp_we),
        .snp_idx (snoop_line),
        .snp_st  (snp_st),
        .loc_we  (loc_we),
        .loc_idx (loc_idx),
        .loc_st  (loc_st),
        .st_q    (st_vec)
    );

    mesi_snoop_unit u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snoop_valid (snoop_valid),
        .snoop_rfo   (snoop_rfo),
        .cur_st      (st_vec[snoop_line]),
        .upd_we      (snp_we),
        .upd_st      (snp_st),
        .resp_valid  (snoop_resp_valid),
        .resp_shared (snoop_resp_shared),
        .resp_supply (snoop_resp_supply)
    );

    mesi_req_fsm #(.NUM_LINES(NUM_LINES), .NUM_PEERS(NUM_PEERS)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .cpu_req_valid    (cpu_req_valid),
        .cpu_req_write    (cpu_req_write),
        .cpu_req_line     (cpu_req_line),
        .cur_st           (st_vec[cpu_req_line]),
        .snoop_valid      (snoop_valid),
        .snoop_line       (snoop_line),
        .bus_grant        (bus_grant),
        .peer_resp_valid  (peer_resp_valid),
        .peer_resp_shared (peer_resp_shared),
        .cpu_done         (cpu_done),
        .cpu_hit          (cpu_hit),
        .bus_req_valid    (bus_req_valid),
        .bus_req_rfo      (bus_req_rfo),
        .bus_req_line     (bus_req_line),
        .loc_we           (loc_we),
        .loc_idx          (loc_idx),
        .loc_st           (loc_st)
    );

    // R6/R8/R11: a snooped RFO leaves the addressed line Invalid.
    a_r6_rfo_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && snoop_rfo |=> st_vec[$past(snoop_line)] == ST_I);

    // R5: a snooped read of a dirty line leaves it Shared.
    a_r5_read_demotes: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && !snoop_rfo && (st_vec[snoop_line] == ST_M) |=>
            st_vec[$past(snoop_line)] == ST_S);

    // R2: a completed RFO leaves the requested line Modified.
    a_r2_rfo_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && !cpu_hit && bus_req_rfo |-> st_vec[bus_req_line] == ST_M);

endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
// Self-checking bench: plays processor, arbiter, peers and snooping agents,
// and predicts every answer from a reference model of the line states.
module mesi_snoop_ctrl_tb_top;

    localparam int NL = 16;
    localparam int NP = 3;
    localparam int IW = $clog2(NL);

    // Model encoding: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
    localparam int MI = 0, MS = 1, ME = 2, MM = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [IW-1:0] cpu_req_line = '0;
    logic          cpu_done, cpu_hit;
    logic          bus_req_valid, bus_req_rfo;
    logic [IW-1:0] bus_req_line;
    logic          bus_grant = 1'b0;
    logic [NP-1:0] peer_resp_valid = '0;
    logic [NP-1:0] peer_resp_shared = '0;
    logic          snoop_valid = 1'b0;
    logic          snoop_rfo = 1'b0;
    logic [IW-1:0] snoop_line = '0;
    logic          snoop_resp_valid, snoop_resp_shared, snoop_resp_supply;

    int n_checks = 0;
    int n_fails  = 0;
    int model [NL];
    int cycles = 0;

    always #4 clk = ~clk;

    mesi_snoop_ctrl #(.NUM_LINES(NL), .NUM_PEERS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_line(cpu_req_line), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .bus_req_valid(bus_req_valid), .bus_req_rfo(bus_req_rfo),
        .bus_req_line(bus_req_line), .bus_grant(bus_grant),
        .peer_resp_valid(peer_resp_valid), .peer_resp_shared(peer_resp_shared),
        .snoop_valid(snoop_valid), .snoop_rfo(snoop_rfo), .snoop_line(snoop_line),
        .snoop_resp_valid(snoop_resp_valid), .snoop_resp_shared(snoop_resp_shared),
        .snoop_resp_supply(snoop_resp_supply)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string snoop_tag(int st);
        case (st)
            MM: return "R5/R6 snoop on Modified";
            ME: return "R11 snoop on Exclusive";
            MS: return "R8 snoop on Shared";
            default: return "R1 snoop on Invalid";
        endcase
    endfunction

    function automatic int snoop_after(int st, bit rfo);
        if (rfo || st == MI) return MI;
        return MS;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    // Check a registered snoop answer against the model, then update it.
    task automatic check_snoop_resp(input int line, input int pre, input bit rfo);
        string t;
        t = snoop_tag(pre);
        check(snoop_resp_valid == 1'b1, t, int'(snoop_resp_valid), 1);
        check(snoop_resp_shared == (pre != MI), t, int'(snoop_resp_shared), int'(pre != MI));
        check(snoop_resp_supply == (pre == MM), t, int'(snoop_resp_supply), int'(pre == MM));
        model[line] = snoop_after(pre, rfo);
    endtask

    task automatic snoop_op(input bit rfo, input int line);
        int pre;
        pre = model[line];
        @(negedge clk);
        snoop_valid = 1'b1; snoop_rfo = rfo; snoop_line = IW'(line);
        @(negedge clk);
        snoop_valid = 1'b0;
        check_snoop_resp(line, pre, rfo);
    endtask

    // One processor access; optionally collides with a same-line snoop.
    task automatic cpu_op(input bit wr, input int line, input logic [NP-1:0] shr,
                          input bit collide, input bit crfo);
        int pre;
        bit need_bus, exp_rfo;
        string t;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_line = IW'(line);
        if (collide) begin
            snoop_valid = 1'b1; snoop_rfo = crfo; snoop_line = IW'(line);
            pre = model[line];
            @(negedge clk);
            snoop_valid = 1'b0;
            check_snoop_resp(line, pre, crfo);
            check(!cpu_done && !bus_req_valid, "R12 stall on collision",
                  int'(cpu_done | bus_req_valid), 0);
        end
        pre = model[line];
        exp_rfo  = wr && (pre == MI || pre == MS);
        need_bus = (pre == MI) || exp_rfo;
        case (pre)
            MM: t = "R4 Modified access";
            ME: t = "R9 Exclusive access";
            MS: t = "R7 Shared access";
            default: t = wr ? "R2 write miss" : "R3 read miss";
        endcase
        if (collide) t = {t, " after R12 collision"};
        @(negedge clk);
        if (!need_bus) begin
            check(cpu_done && cpu_hit && !bus_req_valid, t,
                  int'({cpu_done, cpu_hit, bus_req_valid}), 3'b110);
            cpu_req_valid = 1'b0;
            if (wr) model[line] = MM;
        end else begin
            check(bus_req_valid && !cpu_done, t, int'({bus_req_valid, cpu_done}), 2'b10);
            check(bus_req_rfo == exp_rfo && bus_req_line == IW'(line), t,
                  int'({bus_req_rfo, bus_req_line}), int'({exp_rfo, IW'(line)}));
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk);
                check(bus_req_valid, "R3 request held until grant", int'(bus_req_valid), 1);
            end
            bus_grant = 1'b1;
            @(negedge clk);
            bus_grant = 1'b0;
            for (int i = 0; i < NP; i++) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                check(!cpu_done, "R10 waits for every peer", int'(cpu_done), 0);
                peer_resp_valid = NP'(1) << i;
                peer_resp_shared = shr & (NP'(1) << i);
                @(negedge clk);
                peer_resp_valid = '0;
                peer_resp_shared = '0;
            end
            check(cpu_done && !cpu_hit, t, int'({cpu_done, cpu_hit}), 2'b10);
            cpu_req_valid = 1'b0;
            model[line] = wr ? MM : ((shr != '0) ? MS : ME);
        end
        @(negedge clk);
        check(!cpu_done, "R4 done is one pulse", int'(cpu_done), 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NL; i++) model[i] = MI;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_done && !bus_req_valid && !snoop_resp_valid, "R1 idle after reset",
              int'({cpu_done, bus_req_valid, snoop_resp_valid}), 0);
        // R1: every line answers as Invalid.
        for (int i = 0; i < NL; i++) snoop_op(1'b0, i);

        // R3: read miss, no sharer -> Exclusive; R9 silent upgrade; R4 hits.
        cpu_op(1'b0, 1, 3'b000, 1'b0, 1'b0);
        cpu_op(1'b1, 1, 3'b000, 1'b0, 1'b0);
        cpu_op(1'b0, 1, 3'b000, 1'b0, 1'b0);
        cpu_op(1'b1, 1, 3'b000, 1'b0, 1'b0);
        // R5: snoop read on Modified supplies and demotes; R7 upgrade from Shared.
        snoop_op(1'b0, 1);
        cpu_op(1'b0, 1, 3'b000, 1'b0, 1'b0);
        cpu_op(1'b1, 1, 3'b010, 1'b0, 1'b0);
        // R6: snoop RFO on Modified supplies and invalidates.
        snoop_op(1'b1, 1);
        // R2: write miss.
        cpu_op(1'b1, 2, 3'b000, 1'b0, 1'b0);
        // R3 with a sharer -> Shared; R8 snoops on Shared.
        cpu_op(1'b0, 3, 3'b100, 1'b0, 1'b0);
        snoop_op(1'b0, 3);
        snoop_op(1'b1, 3);
        // R11 snoops on Exclusive.
        cpu_op(1'b0, 4, 3'b000, 1'b0, 1'b0);
        snoop_op(1'b0, 4);
        cpu_op(1'b0, 5, 3'b000, 1'b0, 1'b0);
        snoop_op(1'b1, 5);
        // R12: Exclusive line, write collides with a snoop RFO -> RFO miss.
        cpu_op(1'b0, 6, 3'b000, 1'b0, 1'b0);
        cpu_op(1'b1, 6, 3'b000, 1'b1, 1'b1);
        // R12: Modified line, read collides with a snoop read -> Shared hit.
        cpu_op(1'b0, 6, 3'b000, 1'b1, 1'b0);

        // Random mix over a few lines so states recur.
        for (int k = 0; k < 400; k++) begin
            int line, op;
            line = $urandom_range(0, 5);
            op   = $urandom_range(0, 5);
            case (op)
                0, 1: cpu_op(1'b0, line, NP'($urandom_range(0, 7)), 1'b0, 1'b0);
                2, 3: cpu_op(1'b1, line, NP'($urandom_range(0, 7)), 1'b0, 1'b0);
                4: snoop_op(1'($urandom_range(0, 1)), line);
                default: cpu_op(1'($urandom_range(0, 1)), line, NP'($urandom_range(0, 7)),
                                1'b1, 1'($urandom_range(0, 1)));
            endcase
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule